// File: doc/BRIEF.md
# Descriptor Intake and Run Gate

This block sits in front of a memory-mapped copy engine and merges two descriptor feeds: one from the on-chip descriptor fetch path and one from an external bypass input. Each descriptor names a queue, a source and a destination address, a byte length and a no-DMA flag. The merged stream leaves through a single registered valid/ready output, tagged with the feed it came from. When both feeds compete, a two-way round-robin arbiter orders them. The source that wins a transfer gets the lower priority for the next contest.

A run input gates the whole path. While run is low, both feeds are always ready and every descriptor they present is discarded, so upstream logic never stalls on a stopped engine. A descriptor that has already been captured in the output register when run falls is still delivered. The first cycle in which run is high again is a re-arm cycle. In that cycle no descriptor is taken, the arbiter returns to favouring the fetch path, and the count of descriptors handed out but not yet completed is cleared. A per-queue configuration vector marks which queues take bypass traffic. A bypass descriptor aimed at any other queue is discarded and raises a sticky error flag.

Discarded descriptors are counted in a saturating counter. A registered quiesced flag tells software when it may re-arm: run low, output register empty and no completions outstanding.

Top module: `dsc_intake_gate`

## Requirements
- R1: After reset, out_valid is 0, drop_count is 0, err_illegal is 0 and quiesced is 1.
- R2: While run_en is 0, int_ready and byp_ready are both 1, and no descriptor is loaded into the output register, so out_valid does not rise.
- R3: Every discarded descriptor adds one to drop_count, which can rise by two in one cycle (one per feed). A descriptor counts as discarded when it is presented while stopped, or when it is an illegal bypass descriptor. drop_count saturates at 2^CW-1.
- R4: A bypass queue is legal when qmode_bypass[q] is 1; bit 0 of the vector belongs to queue 0. While running, a bypass descriptor whose queue bit is 0 gets byp_ready=1 and is discarded. Taking a descriptor that names a queue with bit 0 (running or stopped) sets err_illegal, which stays 1 until reset.
- R5: When both feeds hold legal descriptors and the output register can load, the feed named by the round-robin pointer wins. After an accepted transfer, the other feed holds priority. The pointer changes only when a transfer is accepted.
- R6: A lone requesting feed is accepted in the same cycle when the output register is empty or being drained. While out_valid=1 and out_ready=0, neither feed is accepted.
- R7: The output register holds its contents while out_valid=1 and out_ready=0. A loaded descriptor appears on the out_* ports one cycle after its input handshake. out_from_byp is 0 for the fetch feed and 1 for the bypass feed.
- R8: A descriptor held in the output register when run_en falls stays valid and is delivered unchanged.
- R9: In the first cycle with run_en=1 after a cycle with run_en=0, int_ready and byp_ready are 0. After that cycle, the fetch feed holds priority and the outstanding count is zero.
- R10: Each output handshake adds one to an outstanding count. Each cmp_done pulse removes one, and is ignored when the count is zero. In every cycle quiesced equals the previous cycle's value of (run_en=0 and out_valid=0 and outstanding count=0).
- R11: Zero-length and no-DMA descriptors pass through like any other, with len and no-DMA fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Engine run control |
| qmode_bypass | input | 2^QW | Per-queue flag, 1 = queue takes bypass descriptors |
| int_valid | input | 1 | Fetch feed descriptor valid |
| int_ready | output | 1 | Fetch feed ready |
| int_queue | input | QW | Fetch feed queue number |
| int_saddr | input | AW | Fetch feed source address |
| int_daddr | input | AW | Fetch feed destination address |
| int_len | input | LW | Fetch feed byte length |
| int_nodma | input | 1 | Fetch feed no-DMA flag |
| byp_valid | input | 1 | Bypass feed descriptor valid |
| byp_ready | output | 1 | Bypass feed ready |
| byp_queue | input | QW | Bypass feed queue number |
| byp_saddr | input | AW | Bypass feed source address |
| byp_daddr | input | AW | Bypass feed destination address |
| byp_len | input | LW | Bypass feed byte length |
| byp_nodma | input | 1 | Bypass feed no-DMA flag |
| out_valid | output | 1 | Merged descriptor valid |
| out_ready | input | 1 | Request generator ready |
| out_queue | output | QW | Merged queue number |
| out_saddr | output | AW | Merged source address |
| out_daddr | output | AW | Merged destination address |
| out_len | output | LW | Merged byte length |
| out_nodma | output | 1 | Merged no-DMA flag |
| out_from_byp | output | 1 | 1 when the descriptor came from the bypass feed |
| cmp_done | input | 1 | One descriptor finished downstream |
| drop_count | output | CW | Saturating count of discarded descriptors |
| err_illegal | output | 1 | Sticky illegal-bypass error |
| quiesced | output | 1 | Nothing in flight and engine stopped |

## Verification
On every cycle, the assertions check these behaviours:
- Both feeds are ready while stopped, and nothing loads.
- Both feeds stall during the re-arm cycle.
- The output register holds while it is back-pressured.
- The error flag stays set and the drop counter never falls.
- The arbiter pointer moves only on an accepted transfer.
- quiesced never coincides with a valid output.

Only the bench scenarios can show the exact winner order across mixed request patterns, the values of the delivered fields, the saturation point of the counter, and that re-arming clears the outstanding count, which is visible only through quiesced.

// File: rtl/dsc_intake_pkg.sv
package dsc_intake_pkg;
  typedef enum logic {
    SRC_FETCH  = 1'b0,
    SRC_BYPASS = 1'b1
  } dsc_feed_e;
endpackage

// File: rtl/dsc_rr2.sv
module dsc_rr2 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] req,
  input  logic       adv,
  output logic       prio,
  output logic [1:0] gnt
);
  // prio = 0 favours req[0], prio = 1 favours req[1]
  always_comb begin
    gnt[0] = req[0] & (~prio | ~req[1]);
    gnt[1] = req[1] & (prio | ~req[0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) prio <= 1'b0;
    else if (adv)   prio <= gnt[0];
  end

  // R5
  prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(prio))
    else $error("prio moved without an accepted transfer");
endmodule

// File: rtl/dsc_drop_cnt.sv
module dsc_drop_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ev,
  input  logic          err_set,
  output logic [CW-1:0] cnt,
  output logic          err
);
  logic [CW:0] sum;

  always_comb sum = {1'b0, cnt} + (CW+1)'(ev[0]) + (CW+1)'(ev[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      cnt <= sum[CW] ? '1 : sum[CW-1:0];
      if (err_set) err <= 1'b1;
    end
  end

  // R3
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt >= $past(cnt))
    else $error("drop count decreased");

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err)
    else $error("error flag cleared without reset");
endmodule

// File: rtl/dsc_intake_gate.sv
module dsc_intake_gate
  import dsc_intake_pkg::*;
#(
  parameter int QW = 2,
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 4,
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [(1<<QW)-1:0] qmode_bypass,
  input  logic              int_valid,
  output logic              int_ready,
  input  logic [QW-1:0]     int_queue,
  input  logic [AW-1:0]     int_saddr,
  input  logic [AW-1:0]     int_daddr,
  input  logic [LW-1:0]     int_len,
  input  logic              int_nodma,
  input  logic              byp_valid,
  output logic              byp_ready,
  input  logic [QW-1:0]     byp_queue,
  input  logic [AW-1:0]     byp_saddr,
  input  logic [AW-1:0]     byp_daddr,
  input  logic [LW-1:0]     byp_len,
  input  logic              byp_nodma,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QW-1:0]     out_queue,
  output logic [AW-1:0]     out_saddr,
  output logic [AW-1:0]     out_daddr,
  output logic [LW-1:0]     out_len,
  output logic              out_nodma,
  output logic              out_from_byp,
  input  logic              cmp_done,
  output logic [CW-1:0]     drop_count,
  output logic              err_illegal,
  output logic              quiesced
);
  logic          run_q, rearm, run_act;
  logic          illegal, slot_ok, load, prio, hs, dec;
  logic [1:0]    req, gnt;
  logic [PW-1:0] pend;
  dsc_feed_e     feed_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_en;
  end

  assign rearm   = run_en & ~run_q;
  assign run_act = run_en & run_q;
  assign illegal = ~qmode_bypass[byp_queue];
  assign req     = {byp_valid & ~illegal, int_valid};
  assign slot_ok = ~out_valid | out_ready;
  assign load    = run_act & slot_ok & (|gnt);
  assign hs      = out_valid & out_ready;
  assign dec     = cmp_done & (pend != '0);

  dsc_rr2 u_arb (
    .clk  (clk),
    .rst  (rst),
    .clr  (rearm),
    .req  (req),
    .adv  (load),
    .prio (prio),
    .gnt  (gnt)
  );

  assign int_ready = ~run_en | (run_act & slot_ok & (~prio | ~req[1]));
  assign byp_ready = ~run_en | (run_act & (illegal | (slot_ok & (prio | ~int_valid))));

  // output register: holds under back-pressure, keeps content when run falls
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      feed_q    <= SRC_FETCH;
      out_queue <= '0;
      out_saddr <= '0;
      out_daddr <= '0;
      out_len   <= '0;
      out_nodma <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      if (gnt[1]) begin
        feed_q    <= SRC_BYPASS;
        out_queue <= byp_queue;
        out_saddr <= byp_saddr;
        out_daddr <= byp_daddr;
        out_len   <= byp_len;
        out_nodma <= byp_nodma;
      end else begin
        feed_q    <= SRC_FETCH;
        out_queue <= int_queue;
        out_saddr <= int_saddr;
        out_daddr <= int_daddr;
        out_len   <= int_len;
        out_nodma <= int_nodma;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_from_byp = (feed_q == SRC_BYPASS);

  // descriptors handed downstream and not yet completed
  always_ff @(posedge clk) begin
    if (rst || rearm) pend <= '0;
    else              pend <= pend + PW'(hs) - PW'(dec);
  end

  always_ff @(posedge clk) begin
    if (rst) quiesced <= 1'b1;
    else     quiesced <= ~run_en & ~out_valid & (pend == '0);
  end

  dsc_drop_cnt #(.CW(CW)) u_drop (
    .clk     (clk),
    .rst     (rst),
    .ev      ({byp_valid & byp_ready & (illegal | ~run_en), int_valid & ~run_en}),
    .err_set (byp_valid & byp_ready & illegal),
    .cnt     (drop_count),
    .err     (err_illegal)
  );

  // R2
  stop_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> (int_ready && byp_ready))
    else $error("feed stalled while stopped");

  // R2
  stop_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !$rose(out_valid))
    else $error("descriptor loaded while stopped");

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && out_valid && !out_ready) |-> !int_ready)
    else $error("fetch feed accepted into a full register");

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_queue) && $stable(out_saddr)
      && $stable(out_daddr) && $stable(out_len) && $stable(out_nodma) && $stable(out_from_byp)))
    else $error("output changed under back-pressure");

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !run_en) |=> out_valid)
    else $error("in-flight descriptor lost on stop");

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !$past(run_en)) |-> (!int_ready && !byp_ready))
    else $error("handshake in re-arm cycle");

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    quiesced |-> !out_valid)
    else $error("quiesced with a valid output");
endmodule

// File: tb/test_dsc_intake_gate.sv
module test_dsc_intake_gate;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 2;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = 4;
  localparam int PW = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, run_en, cmp_done, out_ready;
  logic [(1<<QW)-1:0] qmode_bypass;
  logic int_valid, int_ready, int_nodma, byp_valid, byp_ready, byp_nodma;
  logic [QW-1:0] int_queue, byp_queue, out_queue;
  logic [AW-1:0] int_saddr, int_daddr, byp_saddr, byp_daddr, out_saddr, out_daddr;
  logic [LW-1:0] int_len, byp_len, out_len;
  logic out_valid, out_nodma, out_from_byp, err_illegal, quiesced;
  logic [CW-1:0] drop_count;

  dsc_intake_gate #(.QW(QW), .AW(AW), .LW(LW), .CW(CW), .PW(PW)) i_dsc_intake_gate (
    .clk(clk), .rst(rst), .run_en(run_en), .qmode_bypass(qmode_bypass),
    .int_valid(int_valid), .int_ready(int_ready), .int_queue(int_queue),
    .int_saddr(int_saddr), .int_daddr(int_daddr), .int_len(int_len), .int_nodma(int_nodma),
    .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_queue(byp_queue),
    .byp_saddr(byp_saddr), .byp_daddr(byp_daddr), .byp_len(byp_len), .byp_nodma(byp_nodma),
    .out_valid(out_valid), .out_ready(out_ready), .out_queue(out_queue),
    .out_saddr(out_saddr), .out_daddr(out_daddr), .out_len(out_len), .out_nodma(out_nodma),
    .out_from_byp(out_from_byp), .cmp_done(cmp_done), .drop_count(drop_count),
    .err_illegal(err_illegal), .quiesced(quiesced)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    int_valid = 0; byp_valid = 0; cmp_done = 0; out_ready = 0;
    int_queue = '0; int_saddr = '0; int_daddr = '0; int_len = '0; int_nodma = 0;
    byp_queue = 2'd2; byp_saddr = '0; byp_daddr = '0; byp_len = '0; byp_nodma = 0;
  endtask

  task automatic do_reset();
    rst = 1; run_en = 0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  bit exp_ov, exp_prio, exp_byp, exp_nd, win, slot;
  logic [QW-1:0] exp_q;
  logic [AW-1:0] exp_sa, exp_da;
  logic [LW-1:0] exp_len;

  initial begin
    qmode_bypass = 4'b1100;
    do_reset();

    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 drop_count", drop_count, 0);
    chk("R1 err_illegal", err_illegal, 0);
    chk("R1 quiesced", quiesced, 1);

    // R2/R3 stopped: both feeds offered, all dropped, count saturates
    int_valid = 1; byp_valid = 1; byp_queue = 2'd3; out_ready = 1;
    for (int k = 0; k < 10; k++) begin
      #1;
      chk("R3 drop_count", drop_count, (2*k > 15) ? 15 : 2*k);
      chk("R2 int_ready", int_ready, 1);
      chk("R2 byp_ready", byp_ready, 1);
      chk("R2 out_valid", out_valid, 0);
      chk("R4 no err on legal drop", err_illegal, 0);
      @(negedge clk);
    end

    // R9 re-arm cycle stalls both feeds
    do_reset();
    run_en = 1; int_valid = 1; byp_valid = 1; byp_queue = 2'd2;
    #1;
    chk("R9 int_ready in re-arm", int_ready, 0);
    chk("R9 byp_ready in re-arm", byp_ready, 0);
    @(negedge clk);
    int_valid = 0; byp_valid = 0;

    // R5/R6/R7/R11 sweep: all request and back-pressure patterns
    do_reset();
    run_en = 1;
    @(negedge clk);
    exp_ov = 0; exp_prio = 0;
    for (int i = 0; i < 96; i++) begin
      logic [2:0] p;
      p = 3'(i ^ (i >> 3));
      chk("R7 out_valid", out_valid, exp_ov);
      if (exp_ov) begin
        chk("R7 out_from_byp", out_from_byp, exp_byp);
        chk("R7 out_queue", out_queue, exp_q);
        chk("R7 out_saddr", out_saddr, exp_sa);
        chk("R7 out_daddr", out_daddr, exp_da);
        chk("R11 out_len", out_len, exp_len);
        chk("R11 out_nodma", out_nodma, exp_nd);
      end
      int_valid = p[0]; byp_valid = p[1]; out_ready = p[2]; cmp_done = 1;
      int_queue = QW'(i); int_saddr = AW'(i * 16); int_daddr = 32'h8000_0000 + AW'(i);
      int_len = LW'(i % 5); int_nodma = i[1];
      byp_queue = QW'(2 + (i & 1)); byp_saddr = 32'h4000_0000 + AW'(i);
      byp_daddr = 32'h2000_0000 + AW'(i); byp_len = LW'(i % 3); byp_nodma = i[0];
      #1;
      slot = !exp_ov || out_ready;
      chk((int_valid && byp_valid) ? "R5 int_ready" : "R6 int_ready",
          int_ready, slot && (!exp_prio || !byp_valid));
      chk((int_valid && byp_valid) ? "R5 byp_ready" : "R6 byp_ready",
          byp_ready, slot && (exp_prio || !int_valid));
      if (slot && (int_valid || byp_valid)) begin
        win = (int_valid && byp_valid) ? exp_prio : byp_valid;
        exp_ov = 1; exp_byp = win; exp_prio = !win;
        exp_q   = win ? byp_queue : int_queue;
        exp_sa  = win ? byp_saddr : int_saddr;
        exp_da  = win ? byp_daddr : int_daddr;
        exp_len = win ? byp_len : int_len;
        exp_nd  = win ? byp_nodma : int_nodma;
      end else if (exp_ov && out_ready) begin
        exp_ov = 0;
      end
      @(negedge clk);
    end

    // R4 illegal bypass while running
    do_reset();
    run_en = 1;
    @(negedge clk);
    out_ready = 1; byp_valid = 1; byp_queue = 2'd0; byp_saddr = 32'h77;
    #1;
    chk("R4 byp_ready on illegal", byp_ready, 1);
    @(negedge clk);
    byp_queue = 2'd3; byp_saddr = 32'h99;
    #1;
    chk("R4 illegal not forwarded", out_valid, 0);
    chk("R4 err set", err_illegal, 1);
    chk("R3 illegal counted", drop_count, 1);
    chk("R6 legal bypass ready", byp_ready, 1);
    @(negedge clk);
    byp_valid = 0;
    #1;
    chk("R7 bypass tag", out_from_byp, 1);
    chk("R7 bypass queue", out_queue, 3);
    chk("R7 bypass saddr", out_saddr, 32'h99);
    @(negedge clk);
    @(negedge clk);
    chk("R4 err sticky", err_illegal, 1);
    chk("R3 legal not counted", drop_count, 1);

    // R8/R10 stop with a descriptor held, then drain and complete
    do_reset();
    run_en = 1;
    @(negedge clk);
    int_valid = 1; int_queue = 2'd1; int_saddr = 32'h55; out_ready = 0;
    #1;
    chk("R6 lone fetch ready", int_ready, 1);
    @(negedge clk);
    int_valid = 0; run_en = 0;
    chk("R7 loaded", out_valid, 1);
    @(negedge clk);
    chk("R8 held after stop", out_valid, 1);
    chk("R8 fields kept", out_saddr, 32'h55);
    chk("R10 not quiesced with valid", quiesced, 0);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R8 delivered", out_valid, 0);
    @(negedge clk);
    chk("R10 outstanding blocks quiesced", quiesced, 0);
    cmp_done = 1;
    @(negedge clk);
    cmp_done = 0;
    chk("R10 before completion seen", quiesced, 0);
    @(negedge clk);
    chk("R10 quiesced after completion", quiesced, 1);

    // R9 re-arm clears the outstanding count
    do_reset();
    run_en = 1;
    @(negedge clk);
    int_valid = 1; out_ready = 1;
    @(negedge clk);
    int_valid = 0;
    @(negedge clk);
    run_en = 0;
    @(negedge clk);
    run_en = 1;
    @(negedge clk);
    run_en = 0;
    chk("R10 not quiesced while running", quiesced, 0);
    @(negedge clk);
    chk("R9 re-arm cleared outstanding", quiesced, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule